// File: doc/BRIEF.md
# Fully Associative Line Lookup

This block is a small fully associative cache of four lines, eight bytes each, addressed by a 12-bit byte address. There is no index field. The low three address bits pick a byte within a line, and the upper nine bits form the tag. Each line has its own tag comparator, and all four comparisons run in parallel. A line that is valid and whose stored tag equals the address tag becomes the active line for the byte read or write. The hit result goes back to the requester on an active-low flag.

On a miss, the requester fetches the missing block elsewhere and picks the victim line itself. It names that line on a 2-bit line-select input while it asserts either the block-fill strobe or the valid-write strobe. For that cycle tag lookup is suspended and only the named line takes the write. After a fill, the requester repeats the original access with the same address, and that access hits.

Top module: `fa_cache`

## Requirements
- R1: The byte offset is addr[2:0] and the tag is addr[11:3]. Byte k of a line is bits [8k+7:8k] of the line's 64-bit value.
- R2: When sel=1 and fill=0 and setv=0, hit_n is 0 exactly when some line is valid and its stored tag equals addr[11:3].
- R3: At most one line may match a given tag; more than one match is flagged as an error in simulation.
- R4: hit_n is 1 whenever sel=0, and also whenever fill=1 or setv=1.
- R5: rdata is byte addr[2:0] of the hit line when rd=1 and the access hits. Otherwise rdata is 0.
- R6: On a hit with wr=1, wdata is written into byte addr[2:0] of the hit line at the clock edge. A write that misses changes no stored byte.
- R7: sel=1 with fill=1 writes tag addr[11:3], all eight bytes of fill_data and valid=1 into line line_sel, leaving the other lines unchanged. The same address hits in the next cycle.
- R8: sel=1 with setv=1 and fill=0 writes vbit into the valid bit of line line_sel only. Tags and data are left unchanged.
- R9: Reset clears every valid bit, so every lookup after reset misses.
- R10: line_sel has no effect unless fill or setv is asserted.
- R11: While fill or setv is asserted, rd and wr have no effect: rdata is 0 and no byte is written through the byte path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; clears valid bits |
| sel | input | 1 | Block select, active high |
| rd | input | 1 | Byte read request |
| wr | input | 1 | Byte write request |
| fill | input | 1 | Block fill strobe: tag, data and valid into line_sel |
| setv | input | 1 | Valid-bit write strobe into line_sel |
| vbit | input | 1 | Value written by setv |
| addr | input | 12 | Byte address: tag in 11:3, offset in 2:0 |
| line_sel | input | 2 | Victim line for fill or setv |
| wdata | input | 8 | Byte write data |
| fill_data | input | 64 | Whole-line data for fill |
| rdata | output | 8 | Read byte, 0 when there is no read hit |
| hit_n | output | 1 | Hit flag, active low |

## Verification
The hardest state to reach from the ports is a line that has a valid tag but is then invalidated while its tag and data stay in place. Restoring the valid bit must bring back exactly the old bytes. The bench fills every line with distinct, arithmetically generated bytes and then toggles one line's valid bit through setv. It checks that this line alone misses and that it later returns its original contents. Stale-data cases are also covered: a refill that replaces one tag, and byte writes driven alongside a valid-bit write. These must leave all untouched lines readable with their predicted values.

// File: rtl/fa_cache.sv
module fa_cache #(
  parameter int LINES = 4,
  parameter int LINE_BYTES = 8,
  parameter int AW = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel,
  input  logic                    rd,
  input  logic                    wr,
  input  logic                    fill,
  input  logic                    setv,
  input  logic                    vbit,
  input  logic [AW-1:0]           addr,
  input  logic [$clog2(LINES)-1:0] line_sel,
  input  logic [7:0]              wdata,
  input  logic [LINE_BYTES*8-1:0] fill_data,
  output logic [7:0]              rdata,
  output logic                    hit_n
);
  localparam int OW = $clog2(LINE_BYTES);
  localparam int LW = $clog2(LINES);
  localparam int TW = AW - OW;
  localparam int DW = LINE_BYTES * 8;

  logic [TW-1:0]    tags  [LINES];
  logic [DW-1:0]    lines [LINES];
  logic [LINES-1:0] vld;
  logic [LINES-1:0] match;
  logic [DW-1:0]    hdata;

  wire [TW-1:0] atag   = addr[AW-1:OW];
  wire [OW-1:0] ofs    = addr[OW-1:0];
  wire          lookup = sel & ~fill & ~setv;

  for (genvar i = 0; i < LINES; i++) begin : g_cmp
    assign match[i] = vld[i] && (tags[i] == atag);
  end

  wire [LINES-1:0] act = match & {LINES{lookup}};
  wire             hit = |act;

  always_comb begin
    hdata = '0;
    for (int i = 0; i < LINES; i++)
      if (act[i]) hdata = hdata | lines[i];
  end

  assign hit_n = ~hit;
  assign rdata = (rd && hit) ? hdata[{ofs, 3'b000} +: 8] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else
      for (int i = 0; i < LINES; i++)
        if (sel && fill && line_sel == LW'(i)) vld[i] <= 1'b1;
        else if (sel && setv && line_sel == LW'(i)) vld[i] <= vbit;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++)
      if (sel && fill && line_sel == LW'(i)) begin
        tags[i]  <= atag;
        lines[i] <= fill_data;
      end else if (wr && act[i]) begin
        lines[i][{ofs, 3'b000} +: 8] <= wdata;
      end
  end
endmodule

module fa_cache_chk #(
  parameter int LINES = 4,
  parameter int TW = 9,
  parameter int LW = 2,
  parameter int DW = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel,
  input logic             wr,
  input logic             fill,
  input logic             setv,
  input logic [LW-1:0]    line_sel,
  input logic [TW-1:0]    atag,
  input logic [LINES-1:0] match,
  input logic [LINES-1:0] vld,
  input logic [TW-1:0]    tags [LINES],
  input logic [DW-1:0]    lines [LINES],
  input logic             hit_n
);
  p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match));
  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n) (!sel || fill || setv) |-> hit_n);
  p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> (vld == '0));
  for (genvar i = 0; i < LINES; i++) begin : g_line
    p_fill_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && fill && line_sel == LW'(i)) |=> (vld[i] && tags[i] == $past(atag)));
    p_miss_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr && hit_n && !fill) |=> $stable(lines[i]));
  end
endmodule

bind fa_cache fa_cache_chk #(.LINES(LINES), .TW(TW), .LW(LW), .DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .fill(fill), .setv(setv),
  .line_sel(line_sel), .atag(atag), .match(match), .vld(vld), .tags(tags),
  .lines(lines), .hit_n(hit_n)
);

// File: tb/test_fa_cache.sv
module test_fa_cache;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic sel = 0, rd = 0, wr = 0, fill = 0, setv = 0, vbit = 0;
  logic [11:0] addr = '0;
  logic [1:0] line_sel = '0;
  logic [7:0] wdata = '0;
  logic [63:0] fill_data = '0;
  logic [7:0] rdata;
  logic hit_n;

  int checks = 0, errors = 0;

  logic        m_vld [4];
  logic [8:0]  m_tag [4];
  logic [7:0]  m_dat [4][8];

  fa_cache i_fa_cache (.clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr),
    .fill(fill), .setv(setv), .vbit(vbit), .addr(addr), .line_sel(line_sel),
    .wdata(wdata), .fill_data(fill_data), .rdata(rdata), .hit_n(hit_n));

  always #(PERIOD/2) clk = ~clk;

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: expected completion, got timeout");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] line_byte(int l, int k);
    return 8'((l * 8 + k) * 13) ^ 8'h5A;
  endfunction

  task automatic cyc(string req, logic s, logic r, logic w, logic f, logic sv, logic vb,
                     logic [11:0] a, logic [1:0] ls, logic [7:0] wd, logic [63:0] fd);
    int hl;
    logic eh;
    logic [7:0] er;
    sel = s; rd = r; wr = w; fill = f; setv = sv; vbit = vb;
    addr = a; line_sel = ls; wdata = wd; fill_data = fd;
    #3;
    hl = -1;
    for (int i = 0; i < 4; i++)
      if (m_vld[i] && m_tag[i] == a[11:3]) hl = i;
    eh = s && !f && !sv && hl >= 0;
    er = (eh && r) ? m_dat[hl][a[2:0]] : 8'h00;
    chk({req, " hit_n"}, 64'(hit_n), 64'(!eh));
    chk({req, " rdata"}, 64'(rdata), 64'(er));
    @(posedge clk);
    if (s && f) begin
      m_vld[ls] = 1'b1; m_tag[ls] = a[11:3];
      for (int k = 0; k < 8; k++) m_dat[ls][k] = fd[k*8 +: 8];
    end else if (s && sv) begin
      m_vld[ls] = vb;
    end else if (w && eh) begin
      m_dat[hl][a[2:0]] = wd;
    end
    #1;
  endtask

  function automatic logic [63:0] pack_line(int l, int seed);
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[k*8 +: 8] = line_byte(l + seed, k);
    return v;
  endfunction

  function automatic logic [8:0] tag_of(int l);
    return 9'(9'h0A5 + l * 37);
  endfunction

  task automatic sweep_reads(string req, logic [1:0] ls);
    for (int l = 0; l < 4; l++)
      for (int k = 0; k < 8; k++)
        cyc(req, 1, 1, 0, 0, 0, 0, {tag_of(l), 3'(k)}, ls, 8'h00, 64'h0);
  endtask

  task automatic do_reset;
    rst_n = 0;
    for (int i = 0; i < 4; i++) m_vld[i] = 0;
    @(posedge clk); #1;
    rst_n = 1;
    @(posedge clk); #1;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_vld[i] = 0; m_tag[i] = '0;
      for (int k = 0; k < 8; k++) m_dat[i][k] = '0;
    end
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    // R9: every lookup misses after reset
    for (int a = 0; a < 4096; a += 97)
      cyc("R9", 1, 1, 0, 0, 0, 0, 12'(a), 2'(a), 8'h00, 64'h0);

    // R7: fill every line; R4: hit_n high during fill
    for (int l = 0; l < 4; l++)
      cyc("R7 R4", 1, 1, 0, 1, 0, 0, {tag_of(l), 3'd0}, 2'(l), 8'h00, pack_line(l, 0));

    // R4: sel low masks hit
    for (int l = 0; l < 4; l++)
      cyc("R4", 0, 1, 0, 0, 0, 0, {tag_of(l), 3'd1}, 2'd0, 8'h00, 64'h0);

    // R1 R2 R5 R10: read every byte, line_sel varied and ignored
    sweep_reads("R1 R2 R5", 2'd0);
    sweep_reads("R10", 2'd3);

    // R2: tags not present miss
    for (int t = 0; t < 512; t += 31)
      if (t != tag_of(0) && t != tag_of(1) && t != tag_of(2) && t != tag_of(3))
        cyc("R2 miss", 1, 1, 0, 0, 0, 0, {9'(t), 3'd4}, 2'd1, 8'h00, 64'h0);

    // R6: byte writes on hits, then a missing write
    for (int l = 0; l < 4; l++)
      cyc("R6", 1, 0, 1, 0, 0, 0, {tag_of(l), 3'(l * 2 + 1)}, 2'd2, 8'(8'hC0 + l), 64'h0);
    cyc("R6 miss write", 1, 0, 1, 0, 0, 0, {9'h1FF, 3'd3}, 2'd0, 8'hEE, 64'h0);
    sweep_reads("R6", 2'd1);

    // R11: byte write and read while a valid write is in progress
    cyc("R11", 1, 1, 1, 0, 1, 1, {tag_of(0), 3'd1}, 2'd3, 8'h77, 64'h0);
    cyc("R11", 1, 1, 1, 1, 0, 0, {tag_of(3), 3'd1}, 2'd3, 8'h66, pack_line(3, 0));
    sweep_reads("R11", 2'd0);

    // R8: clear valid of line 2, then restore it
    cyc("R8", 1, 0, 0, 0, 1, 0, {tag_of(0), 3'd0}, 2'd2, 8'h00, 64'h0);
    sweep_reads("R8 cleared", 2'd2);
    cyc("R8", 1, 0, 0, 0, 1, 1, 12'h000, 2'd2, 8'h00, 64'h0);
    sweep_reads("R8 restored", 2'd0);

    // R7: refill line 1 with a new tag, then repeat the access
    cyc("R7 refill", 1, 1, 0, 1, 0, 0, {9'h033, 3'd5}, 2'd1, 8'h00, pack_line(1, 9));
    for (int k = 0; k < 8; k++)
      cyc("R7 new tag", 1, 1, 0, 0, 0, 0, {9'h033, 3'(k)}, 2'd0, 8'h00, 64'h0);
    cyc("R7 old tag", 1, 1, 0, 0, 0, 0, {tag_of(1), 3'd0}, 2'd0, 8'h00, 64'h0);
    sweep_reads("R7 others", 2'd0);

    // R9: reset mid-run
    do_reset();
    sweep_reads("R9 again", 2'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule